// File: doc/BRIEF.md
# Packet-command PIO burst data sequencer

This block is the device side of the data phase of a packet command carried over programmed I/O. The host first loads a 16-bit transfer limit into the two byte-count registers of the task file and then writes the packet command code. The device answers by requesting a 12-byte command packet, which the host supplies as six 16-bit writes to the data port. The packet is decoded only far enough to recognise a READ(10) request and to extract its block count.

The requested data, 2048 bytes per block, is then handed out in bursts. Before each burst the device writes that burst's byte count back into the byte-count registers and raises its interrupt. The host reads the status register, which clears the interrupt, reads the byte count, and pulls that many bytes through the data port. Each word read from the data port is taken straight from a block-data source stream. After the final burst a completion interrupt is raised and the device returns to ready. A limit that rounds down to zero, or a packet that is not READ(10), ends the command with an abort error.

Top module: `atapi_pio_seq`

## Requirements
- R1: After reset the status register (task-file address 7) reads 0x40, the error register (address 1) reads 0x00 and `irq` is low.
- R2: Writing 0xA0 to address 7 while the device is ready latches the limit from address 4 (low byte) and address 5 (high byte). Status then reads 0x48. The status bits are BSY 0x80, DRDY 0x40, DF 0x20, DRQ 0x08 and ERR 0x01.
- R3: The packet is six data-port writes. Word k carries packet byte 2k in bits 7:0 and byte 2k+1 in bits 15:8. Byte 0 is the opcode (0x28 for READ(10)), byte 7 is the high byte and byte 8 the low byte of the block count. Exactly 1024 data-port words per block are delivered, in source order, each one consuming one source word.
- R4: Each burst is the remaining byte count if that is below the limit, otherwise the limit with bit 0 cleared. At the start of each burst its byte count is readable at addresses 4 (low) and 5 (high).
- R5: Before every burst `irq` is raised and status reads 0x48. A read of address 7 clears `irq`. BSY and DRQ are never shown together.
- R6: After the last word of the last burst, `irq` is raised and status reads 0x40. Data-port reads issued afterwards take nothing from the source.
- R7: A packet command whose limit, with bit 0 cleared, is zero (limit 0 or 1) aborts. `irq` is raised, status reads 0x41 and the error register reads 0x04.
- R8: A packet whose opcode is not 0x28 aborts after the sixth word, with the same indications as R7.
- R9: A READ(10) with block count zero completes at once, with `irq` raised, status 0x40 and no source word consumed.
- R10: When an interrupt is raised in the same cycle as a status read, the interrupt stays set after that read.
- R11: Command codes other than 0xA0 written while the device is ready are ignored: `irq` stays low and status stays 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tf_wr | input | 1 | Task-file register write strobe |
| tf_rd | input | 1 | Task-file register read strobe |
| tf_addr | input | 3 | Task-file register address |
| tf_wdata | input | 8 | Task-file write data |
| tf_rdata | output | 8 | Task-file read data, combinational from the address |
| dp_wr | input | 1 | Data-port write strobe (packet words) |
| dp_rd | input | 1 | Data-port read strobe (burst words) |
| dp_wdata | input | 16 | Data-port write word |
| dp_rdata | output | 16 | Data-port read word |
| src_valid | input | 1 | Source word available |
| src_data | input | 16 | Source word |
| src_ready | output | 1 | Source word taken this cycle |
| irq | output | 1 | Interrupt request to the host |

## Verification
An interrupt can be raised in the same clock cycle as a host status read, and that read would normally clear it. The bench provokes this by placing a status read exactly in the busy cycle that follows packet decoding, which is the cycle whose closing edge opens the first burst. It then judges two things: the value returned by the read must still show BSY and DRDY (0xC0), and `irq` must be high in the following cycle, so the new interrupt wins over the clear.

// File: rtl/atapi_seq_pkg.sv
package atapi_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PKT,
    ST_DECODE,
    ST_PREP,
    ST_XFER
  } seq_state_t;

  // task-file register addresses
  localparam logic [2:0] TF_ERR     = 3'd1;
  localparam logic [2:0] TF_BCLO    = 3'd4;
  localparam logic [2:0] TF_BCHI    = 3'd5;
  localparam logic [2:0] TF_CMDSTAT = 3'd7;

  // status bits
  localparam logic [7:0] STS_BSY  = 8'h80;
  localparam logic [7:0] STS_DRDY = 8'h40;
  localparam logic [7:0] STS_DRQ  = 8'h08;
  localparam logic [7:0] STS_ERR  = 8'h01;

  localparam logic [7:0] ERR_ABORT  = 8'h04;
  localparam logic [7:0] CMD_PACKET = 8'hA0;
  localparam logic [7:0] OPC_READ10 = 8'h28;

endpackage

// File: rtl/atapi_rst_sync.sv
module atapi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/atapi_pkt_capture.sv
module atapi_pkt_capture #(
  parameter int PKT_WORDS = 6,
  parameter int DP_W      = 16,
  parameter int OPC_WORD  = 0,
  parameter int CHI_WORD  = 3,
  parameter int CLO_WORD  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            accept,
  input  logic [DP_W-1:0] wdata,
  output logic            last,
  output logic [7:0]      opcode,
  output logic [15:0]     blocks
);

  localparam int IDX_W = $clog2(PKT_WORDS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PKT_WORDS - 1);
  localparam logic [IDX_W-1:0] IDX_OPC  = IDX_W'(OPC_WORD);
  localparam logic [IDX_W-1:0] IDX_CHI  = IDX_W'(CHI_WORD);
  localparam logic [IDX_W-1:0] IDX_CLO  = IDX_W'(CLO_WORD);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic [7:0]       opc_q, chi_q, clo_q;
  logic             opc_en, chi_en, clo_en;

  always_comb begin
    idx_d  = idx_q;
    idx_en = 1'b0;
    if (clear) begin
      idx_d  = '0;
      idx_en = 1'b1;
    end else if (accept) begin
      idx_d  = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
      idx_en = 1'b1;
    end
  end

  // even packet bytes sit in the low half of a word, odd bytes in the high half
  assign opc_en = accept && (idx_q == IDX_OPC);
  assign chi_en = accept && (idx_q == IDX_CHI);
  assign clo_en = accept && (idx_q == IDX_CLO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      opc_q <= '0;
      chi_q <= '0;
      clo_q <= '0;
    end else begin
      if (idx_en) idx_q <= idx_d;
      if (opc_en) opc_q <= wdata[7:0];
      if (chi_en) chi_q <= wdata[15:8];
      if (clo_en) clo_q <= wdata[7:0];
    end
  end

  assign last   = accept && (idx_q == IDX_LAST);
  assign opcode = opc_q;
  assign blocks = {chi_q, clo_q};

endmodule

// File: rtl/atapi_burst_calc.sv
module atapi_burst_calc #(
  parameter int BC_W  = 16,
  parameter int REM_W = 27
) (
  input  logic [REM_W-1:0] remaining,
  input  logic [BC_W-1:0]  limit,
  output logic [BC_W-1:0]  burst
);

  logic short_tail;

  always_comb begin
    short_tail = remaining < REM_W'(limit);
    if (short_tail) begin
      burst = remaining[BC_W-1:0];
    end else begin
      burst = {limit[BC_W-1:1], 1'b0};
    end
  end

endmodule

// File: rtl/atapi_irq_ctrl.sv
module atapi_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq
);

  logic irq_q, irq_d, irq_en;

  always_comb begin
    irq_d  = irq_q;
    irq_en = 1'b0;
    if (set) begin
      irq_d  = 1'b1;
      irq_en = 1'b1;
    end else if (clr) begin
      irq_d  = 1'b0;
      irq_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (irq_en) begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/atapi_pio_seq.sv
module atapi_pio_seq
  import atapi_seq_pkg::*;
#(
  parameter int TF_DW       = 8,
  parameter int DP_W        = 16,
  parameter int BLK_SHIFT   = 11,
  parameter int PKT_WORDS   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tf_wr,
  input  logic             tf_rd,
  input  logic [2:0]       tf_addr,
  input  logic [TF_DW-1:0] tf_wdata,
  output logic [TF_DW-1:0] tf_rdata,
  input  logic             dp_wr,
  input  logic             dp_rd,
  input  logic [DP_W-1:0]  dp_wdata,
  output logic [DP_W-1:0]  dp_rdata,
  input  logic             src_valid,
  input  logic [DP_W-1:0]  src_data,
  output logic             src_ready,
  output logic             irq
);

  localparam int BC_W  = 2 * TF_DW;
  localparam int REM_W = BC_W + BLK_SHIFT;

  logic rst_sync_n;

  seq_state_t       state_q, state_d;
  logic [BC_W-1:0]  lim_q, lim_d;
  logic [BC_W-1:0]  bc_q, bc_d;
  logic [BC_W-1:0]  burst_q, burst_d;
  logic [BC_W-1:0]  wcnt_q, wcnt_d;
  logic [REM_W-1:0] rem_q, rem_d;
  logic             err_q, err_d;
  logic             lim_en, bc_en, burst_en, wcnt_en, rem_en, err_en;

  logic             cmd_wr, status_rd, pkt_start, pkt_accept, pkt_last;
  logic             xfer_rd, irq_set, in_xfer;
  logic [BC_W-1:0]  lim_even, burst_sz;
  logic [7:0]       pkt_opcode;
  logic [15:0]      pkt_blocks;
  logic [7:0]       status;

  atapi_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  assign cmd_wr     = tf_wr && (tf_addr == TF_CMDSTAT);
  assign status_rd  = tf_rd && (tf_addr == TF_CMDSTAT);
  assign pkt_start  = cmd_wr && (tf_wdata == CMD_PACKET) && (state_q == ST_IDLE);
  assign pkt_accept = dp_wr && (state_q == ST_PKT);
  assign in_xfer    = (state_q == ST_XFER);
  assign xfer_rd    = dp_rd && in_xfer && src_valid;
  assign lim_even   = {bc_q[BC_W-1:1], 1'b0};

  atapi_pkt_capture #(.PKT_WORDS(PKT_WORDS), .DP_W(DP_W)) u_pkt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clear  (pkt_start),
    .accept (pkt_accept),
    .wdata  (dp_wdata),
    .last   (pkt_last),
    .opcode (pkt_opcode),
    .blocks (pkt_blocks)
  );

  atapi_burst_calc #(.BC_W(BC_W), .REM_W(REM_W)) u_burst (
    .remaining (rem_q),
    .limit     (lim_q),
    .burst     (burst_sz)
  );

  atapi_irq_ctrl u_irq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set   (irq_set),
    .clr   (status_rd),
    .irq   (irq)
  );

  // next-state process
  always_comb begin
    state_d  = state_q;
    lim_d    = lim_q;
    lim_en   = 1'b0;
    bc_d     = bc_q;
    bc_en    = 1'b0;
    burst_d  = burst_q;
    burst_en = 1'b0;
    wcnt_d   = wcnt_q;
    wcnt_en  = 1'b0;
    rem_d    = rem_q;
    rem_en   = 1'b0;
    err_d    = err_q;
    err_en   = 1'b0;
    irq_set  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (tf_wr && (tf_addr == TF_BCLO)) begin
          bc_d  = {bc_q[BC_W-1:TF_DW], tf_wdata};
          bc_en = 1'b1;
        end
        if (tf_wr && (tf_addr == TF_BCHI)) begin
          bc_d  = {tf_wdata, bc_q[TF_DW-1:0]};
          bc_en = 1'b1;
        end
        if (pkt_start) begin
          err_en = 1'b1;
          if (lim_even == '0) begin
            err_d   = 1'b1;
            irq_set = 1'b1;
          end else begin
            err_d   = 1'b0;
            lim_d   = bc_q;
            lim_en  = 1'b1;
            state_d = ST_PKT;
          end
        end
      end
      ST_PKT: begin
        if (pkt_last) begin
          state_d = ST_DECODE;
        end
      end
      ST_DECODE: begin
        if (pkt_opcode != OPC_READ10) begin
          err_d   = 1'b1;
          err_en  = 1'b1;
          irq_set = 1'b1;
          state_d = ST_IDLE;
        end else begin
          rem_d   = REM_W'(pkt_blocks) << BLK_SHIFT;
          rem_en  = 1'b1;
          state_d = ST_PREP;
        end
      end
      ST_PREP: begin
        irq_set = 1'b1;
        if (rem_q == '0) begin
          state_d = ST_IDLE;
        end else begin
          burst_d  = burst_sz;
          burst_en = 1'b1;
          bc_d     = burst_sz;
          bc_en    = 1'b1;
          wcnt_d   = burst_sz >> 1;
          wcnt_en  = 1'b1;
          state_d  = ST_XFER;
        end
      end
      ST_XFER: begin
        if (xfer_rd) begin
          wcnt_d  = wcnt_q - 1'b1;
          wcnt_en = 1'b1;
          if (wcnt_q == BC_W'(1)) begin
            rem_d   = rem_q - REM_W'(burst_q);
            rem_en  = 1'b1;
            state_d = ST_PREP;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      lim_q   <= '0;
      bc_q    <= '0;
      burst_q <= '0;
      wcnt_q  <= '0;
      rem_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (lim_en)   lim_q   <= lim_d;
      if (bc_en)    bc_q    <= bc_d;
      if (burst_en) burst_q <= burst_d;
      if (wcnt_en)  wcnt_q  <= wcnt_d;
      if (rem_en)   rem_q   <= rem_d;
      if (err_en)   err_q   <= err_d;
    end
  end

  // status and read-back
  always_comb begin
    unique case (state_q)
      ST_IDLE:   status = STS_DRDY | (err_q ? STS_ERR : 8'h00);
      ST_PKT:    status = STS_DRDY | STS_DRQ;
      ST_XFER:   status = src_valid ? (STS_DRDY | STS_DRQ) : (STS_DRDY | STS_BSY);
      default:   status = STS_DRDY | STS_BSY;
    endcase
  end

  always_comb begin
    unique case (tf_addr)
      TF_ERR:     tf_rdata = err_q ? ERR_ABORT : '0;
      TF_BCLO:    tf_rdata = bc_q[TF_DW-1:0];
      TF_BCHI:    tf_rdata = bc_q[BC_W-1:TF_DW];
      TF_CMDSTAT: tf_rdata = status;
      default:    tf_rdata = '0;
    endcase
  end

  assign dp_rdata  = in_xfer ? src_data : '0;
  assign src_ready = xfer_rd;

endmodule

// File: rtl/atapi_pio_seq_chk.sv
module atapi_pio_seq_chk #(
  parameter int BC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      status,
  input logic            irq,
  input logic            irq_set,
  input logic            status_rd,
  input logic            src_ready,
  input logic            in_xfer,
  input logic [BC_W-1:0] bc_q,
  input logic [BC_W-1:0] lim_q
);

  assert_burst_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_xfer |-> (bc_q <= {lim_q[BC_W-1:1], 1'b0}));

  assert_bsy_drq_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[7] && status[3]));

  assert_irq_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !irq_set) |=> !irq);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq);

  assert_src_in_drq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> status[3]);

  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> (!status[3] && !status[7] && status[6]));

endmodule

bind atapi_pio_seq atapi_pio_seq_chk #(.BC_W(BC_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .status    (status),
  .irq       (irq),
  .irq_set   (irq_set),
  .status_rd (status_rd),
  .src_ready (src_ready),
  .in_xfer   (in_xfer),
  .bc_q      (bc_q),
  .lim_q     (lim_q)
);

// File: tb/atapi_pio_seq_tb_top.sv
module atapi_pio_seq_tb_top;

  logic        clk;
  logic        rst_n;
  logic        tf_wr, tf_rd;
  logic [2:0]  tf_addr;
  logic [7:0]  tf_wdata, tf_rdata;
  logic        dp_wr, dp_rd;
  logic [15:0] dp_wdata, dp_rdata;
  logic        src_valid;
  logic [15:0] src_data;
  logic        src_ready;
  logic        irq;

  int checks;
  int errors;
  bit done;
  logic [15:0] src_idx;
  int exp_idx;

  atapi_pio_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .tf_wr(tf_wr), .tf_rd(tf_rd), .tf_addr(tf_addr),
    .tf_wdata(tf_wdata), .tf_rdata(tf_rdata),
    .dp_wr(dp_wr), .dp_rd(dp_rd), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] pat(input logic [15:0] k);
    return (k * 16'h9e37) ^ 16'h5a5a;
  endfunction

  assign src_data = pat(src_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_idx <= '0;
    else if (src_ready) src_idx <= src_idx + 1'b1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tf_write(input logic [2:0] a, input logic [7:0] d);
    tf_wr = 1'b1; tf_addr = a; tf_wdata = d;
    @(negedge clk);
    tf_wr = 1'b0;
  endtask

  task automatic tf_read(input logic [2:0] a, output logic [7:0] d);
    tf_rd = 1'b1; tf_addr = a;
    #1 d = tf_rdata;
    @(negedge clk);
    tf_rd = 1'b0;
  endtask

  task automatic dp_write(input logic [15:0] w);
    dp_wr = 1'b1; dp_wdata = w;
    @(negedge clk);
    dp_wr = 1'b0;
  endtask

  task automatic dp_read(output logic [15:0] w);
    dp_rd = 1'b1;
    #1 w = dp_rdata;
    @(negedge clk);
    dp_rd = 1'b0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 40; i++) begin
      if (irq) break;
      @(negedge clk);
    end
  endtask

  task automatic send_packet(input logic [7:0] opc, input logic [15:0] blocks);
    dp_write({8'h00, opc});
    dp_write(16'h0000);
    dp_write(16'h0000);
    dp_write({blocks[15:8], 8'h00});
    dp_write({8'h00, blocks[7:0]});
    dp_write(16'h0000);
  endtask

  task automatic start_cmd(input logic [15:0] lim);
    tf_write(3'd4, lim[7:0]);
    tf_write(3'd5, lim[15:8]);
    tf_write(3'd7, 8'hA0);
  endtask

  task automatic run_read(input logic [15:0] lim, input logic [15:0] blocks, input bit coincide);
    logic [7:0]  s, lo, hi;
    logic [15:0] w;
    int rem, burst, mism;
    start_cmd(lim);
    tf_read(3'd7, s);
    chk("R2 status after packet command", s, 8'h48);
    send_packet(8'h28, blocks);
    if (coincide) begin
      @(negedge clk);
      tf_read(3'd7, s);
      chk("R10 status read in busy cycle", s, 8'hC0);
      chk("R10 irq kept after coinciding read", irq, 1);
    end
    rem = int'(blocks) * 2048;
    while (rem > 0) begin
      wait_irq();
      chk("R5 irq before burst", irq, 1);
      tf_read(3'd4, lo);
      tf_read(3'd5, hi);
      burst = (rem < int'(lim)) ? rem : (int'(lim) & ~1);
      chk("R4 burst byte count", {hi, lo}, burst);
      tf_read(3'd7, s);
      chk("R5 status before burst", s, 8'h48);
      chk("R5 irq cleared by status read", irq, 0);
      mism = 0;
      for (int k = 0; k < burst / 2; k++) begin
        dp_read(w);
        if (w != pat(16'(exp_idx))) mism++;
        exp_idx++;
      end
      chk("R3 burst data words", mism, 0);
      rem -= burst;
    end
    wait_irq();
    chk("R6 completion irq", irq, 1);
    tf_read(3'd7, s);
    chk("R6 status after completion", s, 8'h40);
    dp_read(w);
    chk("R6 no source word after completion", int'(src_idx), exp_idx & 16'hffff);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    logic [15:0] lim;
    logic [15:0] blk;
    checks = 0; errors = 0; done = 0; exp_idx = 0;
    tf_wr = 0; tf_rd = 0; tf_addr = '0; tf_wdata = '0;
    dp_wr = 0; dp_rd = 0; dp_wdata = '0; src_valid = 1'b1;
    rst_n = 1'b0;
    void'($urandom(32'd7321));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq after reset", irq, 0);
    tf_read(3'd1, s);
    chk("R1 error reg after reset", s, 8'h00);
    tf_read(3'd7, s);
    chk("R1 status after reset", s, 8'h40);

    // R11 foreign command ignored
    tf_write(3'd7, 8'hEC);
    repeat (3) @(negedge clk);
    chk("R11 irq after foreign command", irq, 0);
    tf_read(3'd7, s);
    chk("R11 status after foreign command", s, 8'h40);

    // directed transfers
    run_read(16'd5120, 16'd1, 1'b0);
    run_read(16'd4097, 16'd3, 1'b0);
    run_read(16'd2048, 16'd2, 1'b0);
    run_read(16'd3000, 16'd1, 1'b1);
    run_read(16'd5121, 16'd10, 1'b0);

    // R7 zero and one limits abort
    for (int v = 0; v < 2; v++) begin
      start_cmd(16'(v));
      chk("R7 irq on bad limit", irq, 1);
      tf_read(3'd1, s);
      chk("R7 error reg on bad limit", s, 8'h04);
      tf_read(3'd7, s);
      chk("R7 status on bad limit", s, 8'h41);
    end

    // R8 wrong opcode
    start_cmd(16'd512);
    send_packet(8'h2A, 16'd1);
    wait_irq();
    chk("R8 irq on wrong opcode", irq, 1);
    tf_read(3'd1, s);
    chk("R8 error reg on wrong opcode", s, 8'h04);
    tf_read(3'd7, s);
    chk("R8 status on wrong opcode", s, 8'h41);

    // R9 zero blocks
    start_cmd(16'd1024);
    send_packet(8'h28, 16'd0);
    wait_irq();
    chk("R9 irq on zero blocks", irq, 1);
    tf_read(3'd7, s);
    chk("R9 status on zero blocks", s, 8'h40);
    chk("R9 no source word consumed", int'(src_idx), exp_idx & 16'hffff);

    // constrained random transfers
    for (int r = 0; r < 6; r++) begin
      lim = 16'(2 + $urandom_range(6000));
      blk = 16'(1 + $urandom_range(2));
      run_read(lim, blk, 1'b0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule